// File: doc/BRIEF.md
# Oversampled Clock and Data Recovery Bank

The block turns return-to-zero pulses from a line receiver's positive and negative slicers into a recovered bit clock and retimed NRZ data. It serves a bank of channels. Each channel runs on one oversample clock at sixteen times the line bit rate: 24.704 MHz for a 1.544 Mb/s line, or 32.768 MHz for a 2.048 Mb/s line. A 4-bit phase counter divides that clock down to the recovered clock. Each leading pulse edge pulls the counter toward the phase that a clean pulse would have, so the recovered clock follows a jittered line. A per-channel rail select chooses between two dual-rail outputs and a single merged rail.

Each channel has a bypass select, and the bank has one global force input. When either is high, the channel drops recovery and passes the raw slicer pulses straight to its rail outputs. Its clock output then carries the XOR of the two raw rails, so that clock recovery can be done outside the block. While force is high, the per-channel bypass selects have no effect.

Each channel runs one state machine with three states: `ST_FREE` (the counter free-runs and waits for a pulse), `ST_TRACK` (the phase is locked to the pulses) and `ST_BYP` (raw pass-through). The transitions are as follows. `ST_FREE` goes to `ST_TRACK` on the first leading edge, which also snaps the phase. `ST_TRACK` goes back to `ST_FREE` after `LOSS_BITS` bit periods with no edge. Any state goes to `ST_BYP` while bypass is requested. `ST_BYP` goes to `ST_FREE` when the request drops.

Top module: `os_cdr_bank`

## Requirements
- R1: While reset is low, every channel is in free-run recovery at phase 0. Its clock output is high and both rail outputs are 0.
- R2: In recovery, the phase rises by one per oversample clock and wraps from 15 to 0. The clock output is high at phases 0 to 7 and low at phases 8 to 15. After reset is released, the clock output stays high for 8 clocks and then goes low.
- R3: In free-run, the first leading edge marks its own cycle as phase 0. A leading edge is a cycle where the registered positive OR negative input is 1 and was 0 one cycle before. The phase is 1 on the next cycle, so the clock output is high on the 5th and 6th clocks after the edge is registered and low on the 9th.
- R4: While tracking, a leading edge seen at phase 0 changes nothing. An edge at phases 1 to 7 holds the phase for one clock. An edge at phases 8 to 15 advances it by two, so a pulse train shifted by one clock is re-centred within one bit.
- R5: In dual-rail recovery, the positive and negative retimed outputs are 1 when a positive or negative pulse was present during phases 0 to 7 of a bit. They update on the clock at phase 8 and hold for 16 clocks.
- R6: When the channel's single-rail select is 1 in recovery, the positive rail output carries the OR of the two retimed rails and the negative rail output is 0.
- R7: After `LOSS_BITS` (default 24) phase wraps without a leading edge, a tracking channel returns to free-run. Bits with no pulse give 0 on both rails.
- R8: In bypass, each rail output repeats its raw input one clock later and the clock output is their XOR. The single-rail select is ignored.
- R9: While the force input is high, every channel is in bypass from the next clock, whatever its bypass select.
- R10: Bypass on one channel leaves the outputs of the other channels unchanged.
- R11: When bypass ends, recovery restarts on the next clock at phase 0 with both retimed rails cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_os | input | 1 | Oversample clock, 16x line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_byp_i | input | 1 | Global force of raw pass-through on all channels |
| byp_sel_i | input | NCH | Per-channel bypass select |
| single_i | input | NCH | Per-channel single-rail select |
| pos_i | input | NCH | Positive slicer pulses |
| neg_i | input | NCH | Negative slicer pulses |
| rclk_o | output | NCH | Recovered clock, or XOR of raw rails in bypass |
| rdat_p_o | output | NCH | Retimed positive or single-rail data, or raw positive rail |
| rdat_n_o | output | NCH | Retimed negative data, or raw negative rail |

## Verification
A wrong phase shows on the clock output within one bit period. It appears as a high or low level at a phase offset where the requirements fix the other level, and the bench samples those offsets in every bit. A wrong state shows just as fast. A channel that misses the return to free-run nudges instead of snapping, which moves the clock by several phases at the first new pulse. A stale bypass state shows at the rails one clock after the inputs change. A retimer that latches at the wrong phase or over the wrong window gives a wrong data bit at the next bit centre.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_BYP   = 2'd2
    } cdr_st_t;

endpackage

// File: rtl/cdr_edge_sync.sv
module cdr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    output logic p_q_o,
    output logic n_q_o,
    output logic lead_o
);

    logic p_q, n_q, any_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q   <= 1'b0;
            n_q   <= 1'b0;
            any_q <= 1'b0;
        end else begin
            p_q   <= pos_i;
            n_q   <= neg_i;
            any_q <= p_q | n_q;
        end
    end

    assign p_q_o  = p_q;
    assign n_q_o  = n_q;
    assign lead_o = (p_q | n_q) & ~any_q;

endmodule

// File: rtl/cdr_phase_fsm.sv
module cdr_phase_fsm
    import cdr_pkg::*;
#(
    parameter int PH_W      = 4,
    parameter int LOSS_BITS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byp_req_i,
    input  logic            lead_i,
    output cdr_st_t         st_o,
    output logic [PH_W-1:0] ph_o,
    output logic            snap_o
);

    localparam logic [PH_W-1:0] PH_MID = PH_W'(1) << (PH_W - 1);
    localparam logic [PH_W-1:0] PH_MAX = '1;
    localparam int              ZC_W   = $clog2(LOSS_BITS + 1);
    localparam logic [ZC_W-1:0] ZC_END = ZC_W'(LOSS_BITS - 1);

    cdr_st_t          st_q, st_d;
    logic [PH_W-1:0]  ph_q, ph_d, ph_nudge;
    logic [ZC_W-1:0]  zc_q, zc_d;
    logic             loss_hit;

    assign loss_hit = (st_q == ST_TRACK) && !lead_i && (ph_q == PH_MAX) && (zc_q == ZC_END);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BYP:   st_d = byp_req_i ? ST_BYP : ST_FREE;
            ST_FREE:  begin
                if (byp_req_i)   st_d = ST_BYP;
                else if (lead_i) st_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (byp_req_i)     st_d = ST_BYP;
                else if (loss_hit) st_d = ST_FREE;
            end
            default:  st_d = ST_FREE;
        endcase
    end

    // phase correction on a leading edge while tracking
    always_comb begin
        if (ph_q == '0)         ph_nudge = PH_W'(1);
        else if (ph_q < PH_MID) ph_nudge = ph_q;
        else                    ph_nudge = ph_q + PH_W'(2);
    end

    // outputs: phase and loss counter
    always_comb begin
        ph_d = ph_q + PH_W'(1);
        zc_d = '0;
        if (byp_req_i || st_q == ST_BYP) begin
            ph_d = '0;
        end else begin
            unique case (st_q)
                ST_FREE:  if (lead_i) ph_d = PH_W'(1);
                ST_TRACK: begin
                    if (lead_i)              ph_d = ph_nudge;
                    else if (ph_q == PH_MAX) zc_d = zc_q + ZC_W'(1);
                    else                     zc_d = zc_q;
                end
                default:  ph_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            zc_q <= '0;
        end else begin
            ph_q <= ph_d;
            zc_q <= zc_d;
        end
    end

    assign st_o   = st_q;
    assign ph_o   = ph_q;
    assign snap_o = (st_q == ST_FREE) && lead_i && !byp_req_i;

    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_BYP && !byp_req_i && !lead_i) |=> ph_q == PH_W'($past(ph_q) + PH_W'(1)));

    a_r4_late_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK && !byp_req_i && lead_i && ph_q != '0 && ph_q < PH_MID)
            |=> ph_q == $past(ph_q));

    a_r4_early_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK && !byp_req_i && lead_i && ph_q >= PH_MID)
            |=> ph_q == PH_W'($past(ph_q) + PH_W'(2)));

    a_r3_snap_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FREE && !byp_req_i && lead_i) |=> (ph_q == PH_W'(1) && st_q == ST_TRACK));

endmodule

// File: rtl/cdr_retimer.sv
module cdr_retimer #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            snap_i,
    input  logic [PH_W-1:0] ph_i,
    input  logic            p_i,
    input  logic            n_i,
    output logic            dp_o,
    output logic            dn_o
);

    localparam logic [PH_W-1:0] PH_MID = PH_W'(1) << (PH_W - 1);

    logic sp_q, sn_q, dp_q, dn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= 1'b0;
            sn_q <= 1'b0;
            dp_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (clr_i) begin
            sp_q <= 1'b0;
            sn_q <= 1'b0;
            dp_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            if (ph_i == PH_MID) begin
                dp_q <= sp_q;
                dn_q <= sn_q;
            end
            if (snap_i) begin
                sp_q <= p_i;
                sn_q <= n_i;
            end else if (ph_i == PH_MID) begin
                sp_q <= 1'b0;
                sn_q <= 1'b0;
            end else if (ph_i < PH_MID) begin
                sp_q <= sp_q | p_i;
                sn_q <= sn_q | n_i;
            end
        end
    end

    assign dp_o = dp_q;
    assign dn_o = dn_q;

    a_r5_hold_off_centre: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ph_i != PH_MID) |=> ($stable(dp_q) && $stable(dn_q)));

endmodule

// File: rtl/cdr_channel.sv
module cdr_channel
    import cdr_pkg::*;
#(
    parameter int PH_W      = 4,
    parameter int LOSS_BITS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byp_req_i,
    input  logic single_i,
    input  logic pos_i,
    input  logic neg_i,
    output logic rclk_o,
    output logic rp_o,
    output logic rn_o,
    output logic byp_act_o
);

    logic            p_q, n_q, lead, snap, dp, dn;
    logic [PH_W-1:0] ph;
    cdr_st_t         st;

    cdr_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .p_q_o  (p_q),
        .n_q_o  (n_q),
        .lead_o (lead)
    );

    cdr_phase_fsm #(.PH_W(PH_W), .LOSS_BITS(LOSS_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byp_req_i (byp_req_i),
        .lead_i    (lead),
        .st_o      (st),
        .ph_o      (ph),
        .snap_o    (snap)
    );

    cdr_retimer #(.PH_W(PH_W)) u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (st == ST_BYP),
        .snap_i (snap),
        .ph_i   (ph),
        .p_i    (p_q),
        .n_i    (n_q),
        .dp_o   (dp),
        .dn_o   (dn)
    );

    always_comb begin
        if (st == ST_BYP) begin
            rclk_o = p_q ^ n_q;
            rp_o   = p_q;
            rn_o   = n_q;
        end else begin
            rclk_o = ~ph[PH_W-1];
            rp_o   = single_i ? (dp | dn) : dp;
            rn_o   = single_i ? 1'b0 : dn;
        end
    end

    assign byp_act_o = (st == ST_BYP);

    a_r8_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
        byp_act_o |-> (rp_o == $past(pos_i) && rn_o == $past(neg_i)
                       && rclk_o == ($past(pos_i) ^ $past(neg_i))));

endmodule

// File: rtl/os_cdr_bank.sv
module os_cdr_bank #(
    parameter int NCH       = 2,
    parameter int PH_W      = 4,
    parameter int LOSS_BITS = 24
) (
    input  logic           clk_os,
    input  logic           rst_n,
    input  logic           force_byp_i,
    input  logic [NCH-1:0] byp_sel_i,
    input  logic [NCH-1:0] single_i,
    input  logic [NCH-1:0] pos_i,
    input  logic [NCH-1:0] neg_i,
    output logic [NCH-1:0] rclk_o,
    output logic [NCH-1:0] rdat_p_o,
    output logic [NCH-1:0] rdat_n_o
);

    logic [NCH-1:0] byp_act;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cdr_channel #(.PH_W(PH_W), .LOSS_BITS(LOSS_BITS)) u_ch (
            .clk       (clk_os),
            .rst_n     (rst_n),
            .byp_req_i (force_byp_i | byp_sel_i[g]),
            .single_i  (single_i[g]),
            .pos_i     (pos_i[g]),
            .neg_i     (neg_i[g]),
            .rclk_o    (rclk_o[g]),
            .rp_o      (rdat_p_o[g]),
            .rn_o      (rdat_n_o[g]),
            .byp_act_o (byp_act[g])
        );
    end

    a_r9_force_all: assert property (@(posedge clk_os) disable iff (!rst_n)
        force_byp_i |=> (&byp_act));

endmodule

// File: tb/os_cdr_bank_bench.sv
module os_cdr_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int LOSS       = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           force_byp = 1'b0;
    logic [NCH-1:0] sel = '0;
    logic [NCH-1:0] single = '0;
    logic [NCH-1:0] pos = '0;
    logic [NCH-1:0] neg = '0;
    logic [NCH-1:0] rclk, rp, rn;

    int n_chk = 0;
    int n_bad = 0;
    logic smp_p, smp_n, rc5, rc6, rc9;

    always #(CLK_PERIOD / 2) clk = ~clk;

    os_cdr_bank #(.NCH(NCH), .PH_W(4), .LOSS_BITS(LOSS)) u_os_cdr_bank (
        .clk_os      (clk),
        .rst_n       (rst_n),
        .force_byp_i (force_byp),
        .byp_sel_i   (sel),
        .single_i    (single),
        .pos_i       (pos),
        .neg_i       (neg),
        .rclk_o      (rclk),
        .rdat_p_o    (rp),
        .rdat_n_o    (rn)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; force_byp = 1'b0; sel = '0; single = '0; pos = '0; neg = '0;
        repeat (3) @(negedge clk);
        chk("R1 rclk ch0", rclk[0], 1);
        chk("R1 rclk ch1", rclk[1], 1);
        chk("R1 rails", {rp, rn}, 0);
        rst_n = 1'b1;
    endtask

    // one bit slot on channel 0: sym 0 none, 1 positive, 2 negative
    task automatic play(input int sym, input int shift);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (c == 5)  rc5 = rclk[0];
            if (c == 6)  rc6 = rclk[0];
            if (c == 9)  rc9 = rclk[0];
            if (c == 13) begin smp_p = rp[0]; smp_n = rn[0]; end
            pos[0] = (sym == 1) && (c >= shift) && (c < shift + 8);
            neg[0] = (sym == 2) && (c >= shift) && (c < shift + 8);
        end
    endtask

    task automatic t_free_run();
        do_reset();
        repeat (7) @(negedge clk);
        chk("R2 phase 7 high", rclk[0], 1);
        @(negedge clk);
        chk("R2 phase 8 low", rclk[0], 0);
        repeat (7) @(negedge clk);
        chk("R2 phase 15 low", rclk[0], 0);
        @(negedge clk);
        chk("R2 wrap high", rclk[0], 1);
        chk("R7 idle rails zero", {rp[0], rn[0]}, 0);
    endtask

    task automatic t_dual();
        int syms[8] = '{1, 2, 0, 1, 1, 2, 0, 2};
        do_reset();
        foreach (syms[i]) begin
            play(syms[i], 0);
            chk("R5 pos rail", smp_p, int'(syms[i] == 1));
            chk("R5 neg rail", smp_n, int'(syms[i] == 2));
            chk("R3 phase 4 high", rc5, 1);
            chk("R3 phase 8 low", rc9, 0);
        end
    endtask

    task automatic t_single();
        int syms[4] = '{2, 1, 0, 2};
        do_reset();
        single[0] = 1'b1;
        foreach (syms[i]) begin
            play(syms[i], 0);
            chk("R6 merged rail", smp_p, int'(syms[i] != 0));
            chk("R6 neg rail zero", smp_n, 0);
        end
        single[0] = 1'b0;
    endtask

    task automatic t_track();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            play(1, 0);
            chk("R4 aligned low", rc9, 0);
        end
        for (int i = 0; i < 3; i++) begin
            play(1, 1);
            chk("R4 late hold high", rc9, 1);
            chk("R4 late data", smp_p, 1);
        end
        for (int i = 0; i < 2; i++) begin
            play(1, 0);
            chk("R4 early skip low", rc9, 0);
            chk("R4 early data", smp_p, 1);
        end
    endtask

    task automatic t_loss();
        do_reset();
        play(1, 0);
        play(1, 0);
        for (int k = 0; k < LOSS + 2; k++) begin
            play(0, 0);
            if (k < 2 || k == LOSS + 1) chk("R7 zero bit", {smp_p, smp_n}, 0);
        end
        repeat (5) @(negedge clk);
        play(1, 0);
        chk("R7 reacquire snap", rc6, 1);
        chk("R7 reacquire data", smp_p, 1);
    endtask

    task automatic t_bypass();
        int pp[4] = '{1, 0, 1, 0};
        int nn[4] = '{0, 1, 1, 0};
        do_reset();
        play(1, 0);
        chk("R5 before bypass", smp_p, 1);
        sel[0] = 1'b1;
        single[0] = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            pos[0] = pp[i][0];
            neg[0] = nn[i][0];
            @(negedge clk);
            chk("R8 raw pos", rp[0], pp[i]);
            chk("R8 raw neg", rn[0], nn[i]);
            chk("R8 xor clock", rclk[0], pp[i] ^ nn[i]);
            chk("R10 other channel", {rp[1], rn[1]}, 0);
        end
        pos[0] = 1'b0;
        neg[0] = 1'b0;
        sel[0] = 1'b0;
        @(negedge clk);
        chk("R11 phase zero", rclk[0], 1);
        chk("R11 rails cleared", {rp[0], rn[0]}, 0);
        single[0] = 1'b0;
    endtask

    task automatic t_force();
        do_reset();
        force_byp = 1'b1;
        repeat (2) @(negedge clk);
        pos[0] = 1'b1;
        neg[1] = 1'b1;
        @(negedge clk);
        chk("R9 ch0 pos", rp[0], 1);
        chk("R9 ch0 neg", rn[0], 0);
        chk("R9 ch0 clock", rclk[0], 1);
        chk("R9 ch1 pos", rp[1], 0);
        chk("R9 ch1 neg", rn[1], 1);
        chk("R9 ch1 clock", rclk[1], 1);
        force_byp = 1'b0;
        pos = '0;
        neg = '0;
        @(negedge clk);
    endtask

    initial begin
        t_free_run();
        t_dual();
        t_single();
        t_track();
        t_loss();
        t_bypass();
        t_force();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule